// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block turns single-word requests from a synchronous host into correctly timed pin activity for a 32K x 8 asynchronous static RAM. The host offers a request with a valid/ready handshake, carrying a write flag, a 15-bit word address and 8 bits of write data. Each read returns one byte together with a one-cycle valid strobe.

On the memory side the block drives active-low chip, write and output enables and the address. It also drives an 8-bit data bus, which is split into an outgoing value, an incoming value and a drive enable. The length of each phase is a whole number of clock cycles, derived from the memory's 12 ns address-access and cycle times, its 6 ns output-enable access time and a clock period set by a parameter. Each count is rounded up and is never less than one cycle.

To keep the bus free of contention, the memory's output drivers are always off before the controller drives the bus. When a write follows a read, idle turnaround cycles are inserted between the two.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, chip, write and output enables are all high (standby), the data bus is released, `hostReady` is high and `rdValid` is low.
- R2: A read holds chip enable and output enable low with write enable high for READ_CYC consecutive cycles, where READ_CYC = max(1, ceil(max(address access, output-enable access, read cycle) / clock period)). This is 3 cycles at a 5 ns clock. The address does not change while chip enable is low.
- R3: The byte on `memDin` during the last read cycle is registered and shown on `rdData`, with `rdValid` high for exactly one cycle. That cycle is the (READ_CYC+1)-th cycle after the edge that accepted the request.
- R4: A write holds chip enable and write enable low for WRITE_CYC = max(1, ceil(write cycle / clock period)) cycles, which is 3 at a 5 ns clock, and drives the write data on the bus. This is followed by one cycle with write enable high, chip enable still low and the bus still driven with the same data.
- R5: The data bus is never driven while output enable is low.
- R6: When a write follows a read, at least TURN_CYC+1 cycles (2 by default) pass with output enable high and the bus released between the end of the read and the first cycle in which the bus is driven.
- R7: A request is taken only on an edge where `hostReady` is high. `hostReady` stays low for the whole access, and each accepted request produces exactly one period of chip enable low.
- R8: Asserting reset during an access forces chip, write and output enables high and releases the data bus at once. Normal accesses work again after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host request present |
| hostReady | output | 1 | Controller can accept a request this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 15 | Word address |
| hostWdata | input | 8 | Write data |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | One-cycle strobe marking rdData |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | 15 | Memory address bus |
| memDout | output | 8 | Value driven onto the memory data bus |
| memDin | input | 8 | Value read from the memory data bus |
| memDoutEn | output | 1 | Drive enable for memDout |

## Verification
The assertions assume the host holds `hostWrite`, `hostAddr` and `hostWdata` steady in any cycle where `hostValid` meets `hostReady`. They also assume reset is the only way an access can be cut short. The bench keeps within these assumptions by raising requests between clock edges and dropping them right after the accepting edge. It also uses a behavioural memory that drives `memDin` only while chip and output enables are low and write enable is high. The memory stores data on the rising edge of write enable, so a write that does not land would show up as a wrong byte on a later read.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_WREC
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic doutEn;
    logic load;
    logic capture;
  } pinStrobe_t;

  function automatic int cyclesFor(input int timePs, input int periodPs);
    int c;
    c = (timePs + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_pkg::*;
#(
  parameter int READ_CYC  = 3,
  parameter int WRITE_CYC = 3,
  parameter int TURN_CYC  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       hostWrite,
  output logic       hostReady,
  output pinStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(READ_CYC, WRITE_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             lastRead;
  logic             accept;

  assign hostReady = (state == ST_IDLE);
  assign accept    = hostValid && hostReady;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    case (state)
      ST_IDLE: if (accept) begin
        if (hostWrite && lastRead) begin
          nextState = ST_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else if (hostWrite) begin
          nextState = ST_WRITE;
          nextCnt   = CNT_W'(WRITE_CYC - 1);
        end else begin
          nextState = ST_READ;
          nextCnt   = CNT_W'(READ_CYC - 1);
        end
      end
      ST_TURN: if (cnt == '0) begin
        nextState = ST_WRITE;
        nextCnt   = CNT_W'(WRITE_CYC - 1);
      end else nextCnt = cnt - 1'b1;
      ST_READ: if (cnt == '0) nextState = ST_IDLE;
               else nextCnt = cnt - 1'b1;
      ST_WRITE: if (cnt == '0) nextState = ST_WREC;
                else nextCnt = cnt - 1'b1;
      ST_WREC: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  // pin strobes follow the state being entered, so the datapath registers them glitch-free
  always_comb begin
    strobe.ceN     = !(nextState inside {ST_READ, ST_WRITE, ST_WREC});
    strobe.weN     = (nextState != ST_WRITE);
    strobe.oeN     = (nextState != ST_READ);
    strobe.doutEn  = (nextState inside {ST_WRITE, ST_WREC});
    strobe.load    = accept;
    strobe.capture = (state == ST_READ) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (strobe.capture) lastRead <= 1'b1;
      else if (nextState == ST_WRITE) lastRead <= 1'b0;
    end
  end

  // R6: the bus-driving write phase is never entered directly from a read
  p_turn_after_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |=> (state != ST_WRITE));

  // R7: a request is never taken during an access
  p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) && hostValid |=> (state != ST_READ) || $past(state == ST_READ));

endmodule

// File: rtl/sram_port_dp.sv
module sram_port_dp
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN    <= 1'b1;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memDoutEn <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      memCeN    <= strobe.ceN;
      memWeN    <= strobe.weN;
      memOeN    <= strobe.oeN;
      memDoutEn <= strobe.doutEn;
      rdValid   <= strobe.capture;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memDout <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        memAddr <= hostAddr;
        memDout <= hostWdata;
      end
      if (strobe.capture) rdData <= memDin;
    end
  end

  // R5: bus drive and memory output enable never overlap
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN);

  // R2: reads only with chip enabled and write enable high
  p_read_pins_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN && memWeN);

  // R2: address held while the chip is selected
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN && $past(!memCeN) |-> $stable(memAddr));

  // R4: write enable low only with chip selected and data driven
  p_write_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN && memDoutEn);

  // R4: data and chip enable still held as write enable rises
  p_we_rise_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memCeN && memDoutEn && $stable(memDout));

  // R3: read strobe lasts one cycle
  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_ADDR_ACC_PS = 12000,
  parameter int T_OE_ACC_PS   = 6000,
  parameter int T_RD_CYC_PS   = 12000,
  parameter int T_WR_CYC_PS   = 12000,
  parameter int TURN_CYC      = 1,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoutEn
);

  localparam int READ_CYC = maxOf(maxOf(cyclesFor(T_ADDR_ACC_PS, CLK_PERIOD_PS),
                                        cyclesFor(T_OE_ACC_PS, CLK_PERIOD_PS)),
                                  cyclesFor(T_RD_CYC_PS, CLK_PERIOD_PS));
  localparam int WRITE_CYC = cyclesFor(T_WR_CYC_PS, CLK_PERIOD_PS);
  localparam int TURN_LEN  = (TURN_CYC < 1) ? 1 : TURN_CYC;

  pinStrobe_t strobe;

  sram_port_seq #(
    .READ_CYC (READ_CYC),
    .WRITE_CYC(WRITE_CYC),
    .TURN_CYC (TURN_LEN)
  ) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .hostValid(hostValid),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .strobe   (strobe)
  );

  sram_port_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDoutEn(memDoutEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  // R1: whenever a request can be taken the memory is in standby
  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> memCeN && memWeN && memOeN && !memDoutEn);

endmodule

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;

  // expected lengths at a 5 ns clock, from the requirements
  localparam int EXP_RD_CYC  = 3;   // R2
  localparam int EXP_WR_CYC  = 3;   // R4
  localparam int EXP_RD_LAT  = 4;   // R3
  localparam int EXP_MIN_GAP = 2;   // R6
  localparam int NVEC = 10;
  // {write, address[14:0], data/expected[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 15'h0012, 8'h5A},
    {1'b1, 15'h7F34, 8'hC3},
    {1'b0, 15'h0012, 8'h5A},
    {1'b1, 15'h4056, 8'hFF},
    {1'b0, 15'h7F34, 8'hC3},
    {1'b0, 15'h4056, 8'hFF},
    {1'b1, 15'h0012, 8'h00},
    {1'b0, 15'h0012, 8'h00},
    {1'b1, 15'h2A78, 8'hA5},
    {1'b0, 15'h2A78, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [14:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic        hostReady, rdValid, memCeN, memWeN, memOeN, memDoutEn;
  logic [7:0]  rdData, memDout, memDin;
  logic [14:0] memAddr;

  always #2.5 clk = ~clk;

  sram_port_ctrl uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .rdData(rdData), .rdValid(rdValid), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDout(memDout), .memDin(memDin),
    .memDoutEn(memDoutEn)
  );

  // behavioural memory, indexed by the low address byte
  logic [7:0] memArr [256];
  logic       memDriving;
  assign memDriving = !memCeN && !memOeN && memWeN;
  assign memDin     = memDriving ? memArr[memAddr[7:0]] : 8'h00;
  always @(posedge memWeN) if (!memCeN) memArr[memAddr[7:0]] = memDout;

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor, sampled between edges
  int oeRun = 0, weRun = 0, lastOeRun = 0, lastWeRun = 0, gap = 0, lastGap = 0;
  int contention = 0, addrMoves = 0, ceFalls = 0;
  bit recOk = 0, readPending = 0, gapAfterRead = 0;
  logic prevCeN = 1, prevWeN = 1, prevOeN = 1, prevDoutEn = 0;
  logic [14:0] prevAddr = '0;

  always @(negedge clk) begin
    if (!memOeN) oeRun++;
    else if (!prevOeN) begin lastOeRun = oeRun; oeRun = 0; end
    if (!memWeN) weRun++;
    else if (!prevWeN) begin
      lastWeRun = weRun; weRun = 0;
      recOk = !memCeN && memDoutEn;
    end
    if (!memOeN) begin gap = 0; readPending = 1; end
    else if (!memDoutEn) gap++;
    if (memDoutEn && !prevDoutEn) begin
      lastGap = gap; gapAfterRead = readPending; readPending = 0;
    end
    if (memDoutEn && !memOeN) contention++;
    if (!memCeN && !prevCeN && memAddr != prevAddr) addrMoves++;
    if (!memCeN && prevCeN) ceFalls++;
    prevCeN = memCeN; prevWeN = memWeN; prevOeN = memOeN;
    prevDoutEn = memDoutEn; prevAddr = memAddr;
  end

  // called at a negedge; returns at a negedge with hostReady high
  task automatic doOp(input logic wr, input logic [14:0] a, input logic [7:0] d,
                      output int lat, output logic [7:0] rd, output bit busyLow);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostValid = 1'b0; hostAddr = ~a; hostWdata = ~d;
    busyLow = !hostReady;
    lat = 1;
    rd = 8'h00;
    if (!wr) begin
      while (!rdValid && lat < 20) begin @(negedge clk); lat++; end
      rd = rdData;
    end
    while (!hostReady) @(negedge clk);
  endtask

  initial begin
    int lat;
    logic [7:0] rd;
    bit busyLow, prevRead;
    int ceBefore;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(memCeN && memWeN && memOeN, "R1 enables high in reset", {memCeN, memWeN, memOeN}, 7);
    chk(!memDoutEn, "R1 bus released in reset", memDoutEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(hostReady && !rdValid, "R1 idle ready", {hostReady, rdValid}, 2);
    chk(memCeN && memWeN && memOeN && !memDoutEn, "R1 idle standby",
        {memCeN, memWeN, memOeN, memDoutEn}, 14);

    prevRead = 0;
    for (int i = 0; i < NVEC; i++) begin
      ceBefore = ceFalls;
      doOp(VEC[i][23], VEC[i][22:8], VEC[i][7:0], lat, rd, busyLow);
      #1;
      chk(busyLow, "R7 ready low during access", busyLow, 1);
      chk(ceFalls == ceBefore + 1, "R7 one chip-enable period per request",
          ceFalls - ceBefore, 1);
      if (VEC[i][23]) begin
        chk(lastWeRun == EXP_WR_CYC, "R4 write enable low length", lastWeRun, EXP_WR_CYC);
        chk(recOk, "R4 recovery cycle holds chip enable and data", recOk, 1);
        if (prevRead) begin
          chk(gapAfterRead, "R6 drive follows read", gapAfterRead, 1);
          chk(lastGap >= EXP_MIN_GAP, "R6 turnaround cycles", lastGap, EXP_MIN_GAP);
        end
      end else begin
        chk(lastOeRun == EXP_RD_CYC, "R2 output enable low length", lastOeRun, EXP_RD_CYC);
        chk(lat == EXP_RD_LAT, "R3 read latency", lat, EXP_RD_LAT);
        chk(rd == VEC[i][7:0], "R3 read data", rd, VEC[i][7:0]);
      end
      prevRead = !VEC[i][23];
      @(negedge clk);
      chk(memCeN && memWeN && memOeN && !memDoutEn, "R1 standby between accesses",
          {memCeN, memWeN, memOeN, memDoutEn}, 14);
    end

    // R8: reset in the middle of a write
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = 15'h119A; hostWdata = 8'h3C;
    @(negedge clk);
    hostValid = 1'b0;
    @(negedge clk);
    chk(!memWeN && memDoutEn, "R8 write under way", {memWeN, memDoutEn}, 1);
    rstN = 1'b0;
    #1;
    chk(memCeN && memWeN && memOeN, "R8 enables forced high", {memCeN, memWeN, memOeN}, 7);
    chk(!memDoutEn, "R8 bus released", memDoutEn, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doOp(1'b0, 15'h2A78, 8'h00, lat, rd, busyLow);
    #1;
    chk(rd == 8'hA5, "R8 read after reset", rd, 8'hA5);
    chk(lat == EXP_RD_LAT, "R8 read latency after reset", lat, EXP_RD_LAT);

    chk(contention == 0, "R5 bus driven while output enable low", contention, 0);
    chk(addrMoves == 0, "R2 address moved while selected", addrMoves, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule